// File: doc/BRIEF.md
# Bank-Switched Upper RAM Controller

This block holds the soft-switch state for a 16 KB RAM expansion that overlays the top 12 KB of an 8-bit processor's address space. Every qualified bus access into the sixteen-address switch page at `$C080`–`$C08F` rewrites four state bits. These bits are the RAM read select, the write enable, the write prearm latch and the bank-2 select. Accesses anywhere else leave the four bits alone.

From the current state, the block steers every access into `$D000`–`$FFFF`. A read goes to the ROM chip select or to the RAM. A write goes to the RAM only while writes are enabled, and is dropped otherwise. The `$D000`–`$DFFF` window has two 4 KB banks. The `$E000`–`$FFFF` window is one shared 8 KB region. A separate auxiliary flag picks which physical copy of the RAM serves both windows.

Writes can be enabled only by two odd switch accesses in a row. A stray single access therefore cannot open the RAM to writes.

Top module: `lcard_switch_ctrl`

## Requirements
- R1: A switch access whose low two offset bits are 00 selects RAM for reads, clears the write enable and clears the prearm latch.
- R2: A switch access whose low two offset bits are 01 selects ROM for reads and sets the prearm latch. The write enable becomes 1 only if the prearm latch was already 1 before this access; otherwise the write enable keeps its value.
- R3: A switch access whose low two offset bits are 10 selects ROM for reads, clears the write enable and clears the prearm latch.
- R4: A switch access whose low two offset bits are 11 selects RAM for reads and sets the prearm latch. The write enable follows the same arming rule as R2.
- R5: On every switch access, offset bit 3 sets the bank: 1 selects bank 1 (`st_bank2`=0) and 0 selects bank 2 (`st_bank2`=1).
- R6: After reset, reads come from ROM, the write enable is 1, bank 2 is selected and the prearm latch is 0.
- R7: A window read asserts `rom_cs` when ROM reads are selected and `ram_cs` when RAM reads are selected. A window write asserts `ram_cs` and `ram_we` only when the write enable is 1, and asserts nothing otherwise. `rom_cs` and `ram_cs` are never both 1.
- R8: Whenever `ram_cs` is 1, `ram_aux` equals `aux_zp`, in both windows and for both reads and writes.
- R9: The RAM address is computed as follows. `$Dxxx` maps to `0x0xxx` in bank 1 and to `0x1xxx` in bank 2. Addresses `$E000`–`$FFFF` map to `0x2000` plus the offset from `$E000`, whatever the bank.
- R10: The state changes only on the clock edge that ends a qualified switch access. Accesses outside the switch page, and switch-page addresses presented while `bus_valid` is 0, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Qualifies the access on the bus for this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Access address |
| aux_zp | input | 1 | Selects the auxiliary RAM copy for both windows |
| rom_cs | output | 1 | ROM chip select for window reads |
| ram_cs | output | 1 | RAM chip select for window accesses |
| ram_we | output | 1 | RAM write strobe |
| ram_aux | output | 1 | 1 selects the auxiliary RAM copy |
| ram_addr | output | 14 | Address inside the 16 KB RAM |
| st_rd_ram | output | 1 | State: reads come from RAM |
| st_wen | output | 1 | State: writes enabled |
| st_prearm | output | 1 | State: prearm latch |
| st_bank2 | output | 1 | State: bank 2 selected |

## Verification
Two functions can meet in one access: testing the prearm latch to decide the write enable, and setting the latch again. Both happen on the second of two back-to-back odd accesses. The bench provokes this with pairs of odd accesses, and also with odd accesses broken up by an even one. It judges the result at the state ports and with window writes. The write enable must appear only after the second odd access of an unbroken pair, and a single odd access must leave `ram_we` silent.

// File: rtl/lcs_pkg.sv
package lcs_pkg;

  typedef struct packed {
    logic rd_ram;
    logic wen;
    logic prearm;
    logic bank2;
  } lc_state_t;

  localparam lc_state_t LC_RESET = '{rd_ram: 1'b0, wen: 1'b1, prearm: 1'b0, bank2: 1'b1};

  // Next state for one switch access at offset off.
  function automatic lc_state_t lc_next(input lc_state_t cur, input logic [3:0] off);
    lc_state_t n;
    n.bank2  = ~off[3];
    n.rd_ram = ~(off[0] ^ off[1]);
    n.prearm = off[0];
    n.wen    = off[0] ? (cur.wen | cur.prearm) : 1'b0;
    return n;
  endfunction

  // RAM offset for a window address: D bank 1 / D bank 2 / shared E-F region.
  function automatic logic [13:0] lc_map(input logic [15:0] a, input logic bank2);
    logic [13:0] r;
    if (a[13]) r = {1'b1, a[12:0]};
    else       r = {1'b0, bank2, a[11:0]};
    return r;
  endfunction

endpackage

// File: rtl/lcs_decode.sv
module lcs_decode #(
  parameter int          AW      = 16,
  parameter logic [11:0] SW_PAGE = 12'hC08,
  parameter logic [15:0] WIN_LO  = 16'hD000
) (
  input  logic          bus_valid,
  input  logic [AW-1:0] bus_addr,
  output logic          sw_hit,
  output logic [3:0]    sw_off,
  output logic          win_hit
);
  localparam int PW = AW - 4;

  always_comb begin
    sw_hit  = bus_valid && (bus_addr[AW-1:4] == SW_PAGE[PW-1:0]);
    sw_off  = bus_addr[3:0];
    win_hit = bus_valid && (bus_addr >= WIN_LO[AW-1:0]);
  end
endmodule

// File: rtl/lcs_state.sv
module lcs_state
  import lcs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_hit,
  input  logic [3:0] sw_off,
  output lc_state_t  st,
  output logic       arm_hit,
  output logic       wen_open
);
  lc_state_t st_q;

  // Named events for the checker.
  assign arm_hit  = sw_hit && sw_off[0] && st_q.prearm;
  assign wen_open = arm_hit && !st_q.wen;
  assign st       = st_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      st_q <= LC_RESET;
    else if (sw_hit) st_q <= lc_next(st_q, sw_off);
  end
endmodule

// File: rtl/lcs_route.sv
module lcs_route
  import lcs_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RAW = 14
) (
  input  lc_state_t      st,
  input  logic           win_hit,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic           aux_zp,
  output logic           rom_cs,
  output logic           ram_cs,
  output logic           ram_we,
  output logic           ram_aux,
  output logic [RAW-1:0] ram_addr
);
  logic rd_go, wr_go;

  always_comb begin
    rd_go    = win_hit && !bus_wr;
    wr_go    = win_hit && bus_wr && st.wen;
    rom_cs   = rd_go && !st.rd_ram;
    ram_cs   = (rd_go && st.rd_ram) || wr_go;
    ram_we   = wr_go;
    ram_aux  = ram_cs && aux_zp;
    ram_addr = ram_cs ? lc_map(bus_addr, st.bank2) : '0;
  end
endmodule

// File: rtl/lcard_switch_ctrl.sv
module lcard_switch_ctrl
  import lcs_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RAW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_valid,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic           aux_zp,
  output logic           rom_cs,
  output logic           ram_cs,
  output logic           ram_we,
  output logic           ram_aux,
  output logic [RAW-1:0] ram_addr,
  output logic           st_rd_ram,
  output logic           st_wen,
  output logic           st_prearm,
  output logic           st_bank2
);
  logic      sw_hit, win_hit, arm_hit, wen_open;
  logic [3:0] sw_off;
  lc_state_t st;

  lcs_decode #(.AW(AW)) u_dec (
    .bus_valid(bus_valid), .bus_addr(bus_addr),
    .sw_hit(sw_hit), .sw_off(sw_off), .win_hit(win_hit)
  );

  lcs_state u_st (
    .clk(clk), .rst_n(rst_n), .sw_hit(sw_hit), .sw_off(sw_off),
    .st(st), .arm_hit(arm_hit), .wen_open(wen_open)
  );

  lcs_route #(.AW(AW), .RAW(RAW)) u_rt (
    .st(st), .win_hit(win_hit), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .aux_zp(aux_zp), .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_aux(ram_aux), .ram_addr(ram_addr)
  );

  assign st_rd_ram = st.rd_ram;
  assign st_wen    = st.wen;
  assign st_prearm = st.prearm;
  assign st_bank2  = st.bank2;
endmodule

// File: rtl/lcs_checker.sv
module lcs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       sw_hit,
  input logic [3:0] sw_off,
  input logic       arm_hit,
  input logic       wen_open,
  input logic       aux_zp,
  input logic       rom_cs,
  input logic       ram_cs,
  input logic       ram_we,
  input logic       ram_aux,
  input logic       st_rd_ram,
  input logic       st_wen,
  input logic       st_prearm,
  input logic       st_bank2
);
  AST_EVEN_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit && !sw_off[0] |=> !st_prearm && !st_wen); // R1
  AST_ODD_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit && sw_off[0] |=> st_prearm); // R2
  AST_WEN_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_wen) |-> $past(arm_hit)); // R4
  AST_OPEN_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    wen_open |=> st_wen); // R2
  AST_BANK_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    sw_hit |=> st_bank2 == !$past(sw_off[3])); // R5
  AST_NO_WE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wen |-> !ram_we); // R7
  AST_CS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rom_cs && ram_cs)); // R7
  AST_AUX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs |-> ram_aux == aux_zp); // R8
  AST_QUIET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_hit |=> $stable({st_rd_ram, st_wen, st_prearm, st_bank2})); // R10
endmodule

bind lcard_switch_ctrl lcs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sw_hit(sw_hit), .sw_off(sw_off),
  .arm_hit(arm_hit), .wen_open(wen_open), .aux_zp(aux_zp),
  .rom_cs(rom_cs), .ram_cs(ram_cs), .ram_we(ram_we), .ram_aux(ram_aux),
  .st_rd_ram(st_rd_ram), .st_wen(st_wen), .st_prearm(st_prearm), .st_bank2(st_bank2)
);

// File: tb/lcard_switch_ctrl_tb.sv
module lcard_switch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic        aux_zp = 1'b0;
  logic        rom_cs, ram_cs, ram_we, ram_aux;
  logic [13:0] ram_addr;
  logic        st_rd_ram, st_wen, st_prearm, st_bank2;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Outputs captured during a window access.
  logic        c_rom, c_ram, c_we, c_aux;
  logic [13:0] c_addr;

  always #4 clk = ~clk;

  lcard_switch_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .aux_zp(aux_zp), .rom_cs(rom_cs), .ram_cs(ram_cs),
    .ram_we(ram_we), .ram_aux(ram_aux), .ram_addr(ram_addr),
    .st_rd_ram(st_rd_ram), .st_wen(st_wen), .st_prearm(st_prearm), .st_bank2(st_bank2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Packed state as {rd_ram, wen, prearm, bank2}.
  function automatic logic [3:0] st_now();
    return {st_rd_ram, st_wen, st_prearm, st_bank2};
  endfunction

  task automatic access(input logic [15:0] a, input logic wr, input logic v);
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_valid = v;
    #1;
    c_rom = rom_cs; c_ram = ram_cs; c_we = ram_we; c_aux = ram_aux; c_addr = ram_addr;
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic sw(input logic [15:0] a);
    access(a, 1'b0, 1'b1);
  endtask

  task automatic t_reset();
    chk("R6 state after reset", {28'd0, st_now()}, 32'b0101);
  endtask

  task automatic t_single_then_pair();
    sw(16'hC088);
    chk("R1 R5 offset 8", {28'd0, st_now()}, 32'b1000);
    sw(16'hC089);
    chk("R2 single odd", {28'd0, st_now()}, 32'b0010);
    access(16'hD000, 1'b1, 1'b1);
    chk("R7 write dropped after one odd", {29'd0, c_ram, c_we, c_rom}, 32'd0);
    sw(16'hC089);
    chk("R2 second odd enables write", {28'd0, st_now()}, 32'b0110);
    access(16'hD123, 1'b1, 1'b1);
    chk("R7 write strobe", {30'd0, c_ram, c_we}, 32'b11);
    chk("R9 bank1 D address", {18'd0, c_addr}, 32'h0123);
    access(16'hD123, 1'b0, 1'b1);
    chk("R7 read from ROM", {30'd0, c_rom, c_ram}, 32'b10);
  endtask

  task automatic t_interrupted();
    sw(16'hC08A);
    chk("R3 offset A", {28'd0, st_now()}, 32'b0000);
    sw(16'hC089);
    sw(16'hC080);
    chk("R1 R5 offset 0 bank2", {28'd0, st_now()}, 32'b1001);
    sw(16'hC08B);
    chk("R4 odd after even stays closed", {28'd0, st_now()}, 32'b1010);
    sw(16'hC08B);
    chk("R4 pair enables write", {28'd0, st_now()}, 32'b1110);
  endtask

  task automatic t_bank2_map();
    sw(16'hC083);
    sw(16'hC083);
    chk("R5 R4 offset 3 pair", {28'd0, st_now()}, 32'b1111);
    access(16'hD456, 1'b0, 1'b1);
    chk("R9 bank2 D address", {17'd0, c_ram, c_addr}, {17'd0, 1'b1, 14'h1456});
    access(16'hF00F, 1'b0, 1'b1);
    chk("R9 shared E-F address", {18'd0, c_addr}, 32'h300F);
    access(16'hCFFF, 1'b0, 1'b1);
    chk("R7 below window no select", {30'd0, c_rom, c_ram}, 32'd0);
  endtask

  task automatic t_aux();
    aux_zp = 1'b1;
    access(16'hE010, 1'b0, 1'b1);
    chk("R8 aux read E window", {17'd0, c_aux, c_addr}, {17'd0, 1'b1, 14'h2010});
    access(16'hD005, 1'b1, 1'b1);
    chk("R8 aux write D window", {30'd0, c_we, c_aux}, 32'b11);
    aux_zp = 1'b0;
    access(16'hD005, 1'b1, 1'b1);
    chk("R8 main write D window", {30'd0, c_we, c_aux}, 32'b10);
  endtask

  task automatic t_quiet();
    logic [3:0] snap;
    snap = st_now();
    access(16'hC090, 1'b0, 1'b1);
    access(16'hC07F, 1'b1, 1'b1);
    access(16'hC08A, 1'b0, 1'b0);
    access(16'hD000, 1'b1, 1'b1);
    chk("R10 non-switch accesses keep state", {28'd0, st_now()}, {28'd0, snap});
    sw(16'hC08A);
    access(16'hD000, 1'b1, 1'b1);
    chk("R10 R7 new map on next access", {29'd0, c_rom, c_ram, c_we}, 32'd0);
    access(16'hD000, 1'b0, 1'b1);
    chk("R7 ROM read after offset A", {30'd0, c_rom, c_ram}, 32'b10);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_then_pair();
    t_interrupted();
    t_bank2_map();
    t_aux();
    t_quiet();
    finish_up();
  end
endmodule